// File: doc/BRIEF.md
# Burst Cache Line Fill Engine

The engine sits between a cache's miss path and a memory port that returns data in bursts. When a miss is presented, the engine accepts it with a valid/ready handshake. It clears the offset bits of the address so the request lands on a line boundary, and it issues one burst read. The returned beats are collected in a line buffer in arrival order. Once the last beat is in, the whole line goes to the cache array with a single write pulse. Nothing is installed until every beat has arrived.

By default a line is 64 bytes, carried as eight 8-byte beats on a 64-byte boundary. Setting the `LEGACY` parameter selects 32-byte lines on a 32-byte boundary, carried as four 8-byte beats. If a beat comes back flagged bad, the buffered data is dropped, no line is written and the requester sees a one-cycle error pulse. Tag lookup, replacement, write-back and coherence are handled elsewhere.

Top module: `line_fill_engine`

## Requirements
- R1: After synchronous active-high reset the engine is idle: `miss_ready` is 1 and `mem_req_valid`, `line_we` and `fill_err` are 0.
- R2: The request address keeps the miss address bits above the line offset, and its offset bits (6 bits by default, 5 in legacy mode) are zero. `line_addr` carries the same aligned address.
- R3: Each accepted miss raises `mem_req_valid` in the next cycle. It stays high until the cycle in which `mem_req_ready` is seen and is low afterwards.
- R4: `miss_ready` is 0 from the cycle after a miss is accepted until the fill ends. The fill ends in the cycle after `line_we`, or in the cycle `fill_err` is high. While `miss_ready` is 0 no further miss is taken.
- R5: Beat k of the burst (k counted from 0 in arrival order) lands in `line_data[k*64 +: 64]`.
- R6: `line_we` is high for exactly one cycle: the cycle after the final beat (beat 7, or beat 3 in legacy mode) is captured.
- R7: `line_we` never rises before the last beat. Beats strobed while no burst is being collected have no effect on the written line.
- R8: A beat with `mem_beat_err` set ends the fill. No `line_we` follows for that miss, and `fill_err` is high for one cycle, the cycle after that beat. `line_data` reads all zero in that cycle.
- R9: With `LEGACY=1` a line is 32 bytes, carried as 4 beats on a 32-byte boundary. Address bit 5 passes through to the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Engine can accept a miss |
| miss_addr | input | ADDR_W | Byte address that missed |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Line-aligned burst start address |
| mem_beat_valid | input | 1 | A burst beat is present |
| mem_beat_data | input | BEAT_W | Beat payload |
| mem_beat_err | input | 1 | Beat is flagged bad |
| line_we | output | 1 | One-cycle write of the full line |
| line_addr | output | ADDR_W | Aligned line address for the write |
| line_data | output | BEATS*BEAT_W | Assembled line |
| fill_err | output | 1 | One-cycle error pulse to the requester |

## Verification
The bench targets misses whose offset bits are all ones. A design that did not clear the offset bits would request a misaligned burst, and a design that cleared too many bits would drop address bit 5 in legacy mode. Errors are injected on the first and on the last beat. A design that wrote early, or that kept a partial line, would then pulse `line_we` or leave stale data on `line_data`. Stray beats are sent while the request is still waiting and after an aborted fill. A design that collected those beats would shift the line contents or write a phantom line. Random gaps between beats and random request stalls check that the write comes exactly one cycle after the last beat.

// File: rtl/line_fill_engine.sv
module line_fill_engine #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 64,
  parameter bit LEGACY = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           miss_valid,
  output logic                           miss_ready,
  input  logic [ADDR_W-1:0]              miss_addr,
  output logic                           mem_req_valid,
  input  logic                           mem_req_ready,
  output logic [ADDR_W-1:0]              mem_req_addr,
  input  logic                           mem_beat_valid,
  input  logic [BEAT_W-1:0]              mem_beat_data,
  input  logic                           mem_beat_err,
  output logic                           line_we,
  output logic [ADDR_W-1:0]              line_addr,
  output logic [(LEGACY ? 4 : 8)*BEAT_W-1:0] line_data,
  output logic                           fill_err
);
  localparam int BEATS = LEGACY ? 4 : 8;
  localparam int OFS_W = LEGACY ? 5 : 6;
  localparam int CNT_W = $clog2(BEATS);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_COLLECT, S_WRITE} state_t;
  state_t state;

  logic [CNT_W-1:0]        cnt;
  logic [ADDR_W-OFS_W-1:0] base_q;
  logic                    err_q;
  logic                    take_beat;
  logic                    bad_beat;
  logic                    last_beat;

  assign take_beat = (state == S_COLLECT) && mem_beat_valid;
  assign bad_beat  = take_beat && mem_beat_err;
  assign last_beat = cnt == CNT_W'(BEATS - 1);

  assign miss_ready    = state == S_IDLE;
  assign mem_req_valid = state == S_REQ;
  assign line_we       = state == S_WRITE;
  assign fill_err      = err_q;
  assign mem_req_addr  = {base_q, OFS_W'(0)};
  assign line_addr     = {base_q, OFS_W'(0)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (state)
        S_IDLE: if (miss_valid) begin
          base_q <= miss_addr[ADDR_W-1:OFS_W];
          state  <= S_REQ;
        end
        S_REQ: if (mem_req_ready) begin
          cnt   <= '0;
          state <= S_COLLECT;
        end
        S_COLLECT: if (mem_beat_valid) begin
          if (mem_beat_err) begin
            err_q <= 1'b1;
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (last_beat) state <= S_WRITE;
          end
        end
        default: begin
          cnt   <= '0;
          state <= S_IDLE;
        end
      endcase
    end
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    logic [BEAT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst || bad_beat)
        slot_q <= '0;
      else if (take_beat && cnt == CNT_W'(i))
        slot_q <= mem_beat_data;
    end
    assign line_data[i*BEAT_W +: BEAT_W] = slot_q;
  end

endmodule

// File: rtl/line_fill_engine_chk.sv
module line_fill_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_beat_valid,
  input logic              line_we,
  input logic              fill_err
);
  AST_REQ_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> mem_req_addr[ADDR_W-1:OFS_W] == $past(miss_addr[ADDR_W-1:OFS_W])); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid); // R3
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R3
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !miss_ready); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    line_we |=> !line_we); // R6
  AST_WE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    $rose(line_we) |-> $past(mem_beat_valid)); // R7
  AST_ERR_NO_WE: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> !line_we && !$past(line_we)); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fill_err |=> !fill_err); // R8
endmodule

bind line_fill_engine line_fill_engine_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .miss_ready(miss_ready), .miss_addr(miss_addr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_beat_valid(mem_beat_valid),
  .line_we(line_we), .fill_err(fill_err)
);

// File: tb/line_fill_engine_test.sv
module line_fill_engine_test;
  logic clk = 0, rst = 1, sel = 0;
  logic miss_valid = 0, mem_req_ready = 0, mem_beat_valid = 0, mem_beat_err = 0;
  logic [31:0] miss_addr = 0;
  logic [63:0] mem_beat_data = 0;
  int checks = 0, fails = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  logic mr_n, rv_n, we_n, fe_n, mr_l, rv_l, we_l, fe_l;
  logic [31:0] ra_n, la_n, ra_l, la_l;
  logic [511:0] ld_n;
  logic [255:0] ld_l;

  line_fill_engine uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid & ~sel), .miss_ready(mr_n),
    .miss_addr(miss_addr), .mem_req_valid(rv_n), .mem_req_ready(mem_req_ready & ~sel),
    .mem_req_addr(ra_n), .mem_beat_valid(mem_beat_valid & ~sel),
    .mem_beat_data(mem_beat_data), .mem_beat_err(mem_beat_err),
    .line_we(we_n), .line_addr(la_n), .line_data(ld_n), .fill_err(fe_n));

  line_fill_engine #(.LEGACY(1'b1)) uut_legacy (
    .clk(clk), .rst(rst), .miss_valid(miss_valid & sel), .miss_ready(mr_l),
    .miss_addr(miss_addr), .mem_req_valid(rv_l), .mem_req_ready(mem_req_ready & sel),
    .mem_req_addr(ra_l), .mem_beat_valid(mem_beat_valid & sel),
    .mem_beat_data(mem_beat_data), .mem_beat_err(mem_beat_err),
    .line_we(we_l), .line_addr(la_l), .line_data(ld_l), .fill_err(fe_l));

  wire         v_mr = sel ? mr_l : mr_n;
  wire         v_rv = sel ? rv_l : rv_n;
  wire         v_we = sel ? we_l : we_n;
  wire         v_fe = sel ? fe_l : fe_n;
  wire [31:0]  v_ra = sel ? ra_l : ra_n;
  wire [31:0]  v_la = sel ? la_l : la_n;
  wire [511:0] v_ld = sel ? {256'b0, ld_l} : ld_n;

  function automatic logic [31:0] aligned(input logic [31:0] a, input bit leg);
    return leg ? {a[31:5], 5'b0} : {a[31:6], 6'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // err_at < 0: no error; stray: junk beat while the request waits
  task automatic fill(input logic [31:0] addr, input int err_at, input int req_wait, input bit stray);
    int nb = sel ? 4 : 8;
    logic [511:0] exp = '0;
    chk(v_mr == 1'b1, "R4 idle ready", v_mr, 1);
    miss_valid = 1; miss_addr = addr;
    step();
    miss_valid = 0; miss_addr = $urandom;
    chk(v_mr == 1'b0, "R4 busy", v_mr, 0);
    chk(v_rv == 1'b1, "R3 req raised", v_rv, 1);
    chk(v_ra == aligned(addr, sel), sel ? "R9 legacy align" : "R2 align", v_ra, aligned(addr, sel));
    for (int w = 0; w < req_wait; w++) begin
      if (stray && w == 0) begin mem_beat_valid = 1; mem_beat_data = 64'hDEAD_BEEF_0BAD_F00D; end
      step();
      mem_beat_valid = 0;
      chk(v_rv == 1'b1, "R3 req held", v_rv, 1);
    end
    mem_req_ready = 1;
    step();
    mem_req_ready = 0;
    chk(v_rv == 1'b0, "R3 req dropped", v_rv, 0);
    for (int k = 0; k < nb; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      repeat ($urandom_range(0, 2)) begin
        step();
        chk(v_we == 1'b0, "R7 no early write", v_we, 0);
      end
      mem_beat_valid = 1; mem_beat_data = d; mem_beat_err = (k == err_at);
      exp[k*64 +: 64] = d;
      step();
      mem_beat_valid = 0; mem_beat_err = 0;
      if (k == err_at) begin
        chk(v_fe == 1'b1, "R8 err pulse", v_fe, 1);
        chk(v_we == 1'b0, "R8 no write", v_we, 0);
        chk(v_ld == '0, "R8 buffer dropped", v_ld, 0);
        chk(v_mr == 1'b1, "R4 ready after err", v_mr, 1);
        step();
        chk(v_fe == 1'b0, "R8 err single", v_fe, 0);
        chk(v_we == 1'b0, "R8 still no write", v_we, 0);
        return;
      end
      if (k < nb - 1) chk(v_we == 1'b0, "R7 partial line", v_we, 0);
    end
    chk(v_we == 1'b1, "R6 write strobe", v_we, 1);
    chk(v_fe == 1'b0, "R8 no err", v_fe, 0);
    chk(v_la == aligned(addr, sel), "R2 line addr", v_la, aligned(addr, sel));
    chk(v_ld == exp, sel ? "R9 legacy line" : "R5 beat order", v_ld, exp);
    chk(v_mr == 1'b0, "R4 busy in write", v_mr, 0);
    step();
    chk(v_we == 1'b0, "R6 single pulse", v_we, 0);
    chk(v_mr == 1'b1, "R4 ready after write", v_mr, 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) step();
    rst = 0;
    for (int m = 0; m < 2; m++) begin
      sel = m[0];
      chk(v_mr == 1 && v_rv == 0 && v_we == 0 && v_fe == 0, "R1 reset state",
          {v_mr, v_rv, v_we, v_fe}, 4'b1000);
    end
    sel = 0;
    fill(32'hFFFF_FFFF, -1, 0, 0);
    fill(32'h1234_567F, 0, 1, 0);
    mem_beat_valid = 1; mem_beat_data = 64'h1;
    step();
    mem_beat_valid = 0;
    chk(v_we == 1'b0 && v_mr == 1'b1, "R7 stray beat ignored", v_we, 0);
    fill(32'h0000_0040, 7, 2, 0);
    fill(32'hABCD_EF3F, -1, 3, 1);
    for (int i = 0; i < 40; i++)
      fill($urandom, ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 7)) : -1,
           $urandom_range(0, 3), $urandom_range(0, 1));
    sel = 1;
    step();
    fill(32'h0000_0020, -1, 0, 0);
    fill(32'hFFFF_FFFF, 3, 1, 0);
    fill(32'h8765_43BF, -1, 2, 1);
    for (int i = 0; i < 15; i++)
      fill($urandom | 32'h20, ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 3)) : -1,
           $urandom_range(0, 3), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule